// File: doc/BRIEF.md
# USB PHY Interrupt Latch Unit

This block watches five status lines coming from a USB PHY's analog detectors: host disconnect, VBUS valid, session valid, session end and ID ground. Software, or a link controller, reads their live levels through a read-only status register. Edges on the lines are caught in a latch register that clears itself when read. Per-source enable vectors pick which edges count, one for rising edges and one for falling edges. An interrupt output stays high while any latch bit is set, so the link knows a read is due.

Each source is first conditioned into an effective value, and both the status view and the edge detector work on that value. Host disconnect counts only when both line pulldowns are on, which is host mode, and it is held low during low-power mode. ID ground counts only after the ID pull-up has been on for a settle window, which is counted in clock cycles. Entering low-power mode wipes the latch register, and so does entering a serial mode.

Top module: `usb_irq_latch_unit`

## Requirements
- R1: A read at address 0x13 returns the effective source levels in bits 4:0, in the order bit0 host disconnect, bit1 VBUS valid, bit2 session valid, bit3 session end, bit4 ID ground. Bits 7:5 read 0. Any address other than 0x13 or 0x14 reads 0.
- R2: A 0 to 1 change of an effective source whose rise enable bit is 1 sets that source's latch bit at the next clock edge. The latch reads at address 0x14 with the same bit order as R1, and bits 7:5 read 0.
- R3: A 1 to 0 change of an effective source whose fall enable bit is 1 sets that source's latch bit at the next clock edge.
- R4: A source with both enable bits at 0 never sets its latch bit. An edge whose direction is not enabled is ignored.
- R5: A read strobe at address 0x14 returns the latch contents as they stood before the clock edge, then clears every latch bit at that edge. An enabled edge in the same cycle as the read stays latched.
- R6: The first cycle in which the low-power input is high clears every latch bit. Edges in that same cycle are dropped.
- R7: The first cycle in which the serial-mode input is high clears every latch bit.
- R8: Host disconnect reads as 0 and is never latched unless both the D+ and D- pulldown inputs are 1.
- R9: While the low-power input is high, the host disconnect status bit reads 0.
- R10: ID ground reads as 0 and is not latched until the ID pull-up input has been 1 for ID_SETTLE_CYCLES consecutive cycles. Dropping the pull-up restarts the wait.
- R11: irq_o is 1 exactly when at least one latch bit is set.
- R12: After reset the latch register is 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_disc_i | input | 1 | Host disconnect detector level |
| vbus_valid_i | input | 1 | VBUS valid detector level |
| sess_valid_i | input | 1 | Session valid detector level |
| sess_end_i | input | 1 | Session end detector level |
| id_gnd_i | input | 1 | ID ground detector level |
| dp_pulldown_i | input | 1 | D+ pulldown enabled |
| dm_pulldown_i | input | 1 | D- pulldown enabled |
| id_pullup_i | input | 1 | ID pull-up enabled |
| rise_en_i | input | 5 | Per-source rising-edge enable |
| fall_en_i | input | 5 | Per-source falling-edge enable |
| low_power_i | input | 1 | High while in low-power mode |
| serial_mode_i | input | 1 | High while in 6-pin or 3-pin serial mode |
| reg_addr_i | input | 8 | Register read address |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt, high while any latch bit is set |

## Verification
The hardest case to reach from the ports is an enabled edge that lands in the same cycle as a clearing read. The stimulus changes VBUS valid and raises the read strobe within one drive window. It then expects the old contents from that read and the new bit from the next one. Two other edges also need precise timing. Low-power entry forces host disconnect to fall in the very cycle that the entry clear fires, so that edge must be dropped. Leaving low power raises it again, and that edge must be latched. The ID settle window is broken part-way by dropping the pull-up, which shows that the wait restarts rather than resumes.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned NUM_SRC = 5;

  typedef enum logic [2:0] {
    SRC_HOST_DISC  = 3'd0,
    SRC_VBUS       = 3'd1,
    SRC_SESS_VALID = 3'd2,
    SRC_SESS_END   = 3'd3,
    SRC_ID_GND     = 3'd4
  } src_idx_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_id_qualify.sv
module irq_id_qualify #(
  parameter int unsigned SETTLE_CYCLES = 3_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pullup_i,
  output logic valid_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!pullup_i)     cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign valid_o = pullup_i && (cnt_q == CNT_MAX);

  // R10: losing the pull-up restarts the settle window
  a_r10_wait_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pullup_i |=> !valid_o);
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] rise_en_i,
  input  logic [N-1:0] fall_en_i,
  output logic [N-1:0] event_o
);
  logic [N-1:0] prev_q;
  logic         armed_q;

  // first cycle after reset has no valid history
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    logic rise, fall;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= src_i[i];
    end
    assign rise       = src_i[i] & ~prev_q[i];
    assign fall       = ~src_i[i] & prev_q[i];
    assign event_o[i] = armed_q & ((rise_en_i[i] & rise) | (fall_en_i[i] & fall));
  end
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] event_i,
  input  logic         rd_clr_i,
  input  logic         low_power_i,
  input  logic         serial_i,
  output logic [N-1:0] latch_o,
  output logic         mode_clr_o,
  output logic         irq_o
);
  logic [N-1:0] latch_q, latch_d;
  logic         lp_q, ser_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q  <= 1'b0;
      ser_q <= 1'b0;
    end else begin
      lp_q  <= low_power_i;
      ser_q <= serial_i;
    end
  end

  assign mode_clr_o = (low_power_i & ~lp_q) | (serial_i & ~ser_q);

  always_comb begin
    if (mode_clr_o)    latch_d = '0;
    else if (rd_clr_i) latch_d = event_i;            // read clears, new events survive
    else               latch_d = latch_q | event_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) latch_q <= '0;
    else         latch_q <= latch_d;
  end

  assign latch_o = latch_q;
  assign irq_o   = |latch_q;

  // R6/R7: mode entry leaves nothing pending
  a_r6_entry_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_clr_o |=> (latch_o == '0) && !irq_o);
  // R5: an edge colliding with a clearing read is kept
  a_r5_read_keeps_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !mode_clr_o && (|event_i)) |=> irq_o);
endmodule

// File: rtl/usb_irq_latch_unit.sv
module usb_irq_latch_unit
  import usb_irq_pkg::*;
#(
  parameter int unsigned ADDR_W           = 8,
  parameter int unsigned DATA_W           = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h13,
  parameter logic [ADDR_W-1:0] LATCH_ADDR  = 8'h14,
  parameter int unsigned ID_SETTLE_CYCLES  = 3_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_disc_i,
  input  logic              vbus_valid_i,
  input  logic              sess_valid_i,
  input  logic              sess_end_i,
  input  logic              id_gnd_i,
  input  logic              dp_pulldown_i,
  input  logic              dm_pulldown_i,
  input  logic              id_pullup_i,
  input  logic [4:0]        rise_en_i,
  input  logic [4:0]        fall_en_i,
  input  logic              low_power_i,
  input  logic              serial_mode_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  src_vec_t src_eff, events, latch;
  logic     id_valid, host_mode, rd_clr, mode_clr;

  irq_id_qualify #(.SETTLE_CYCLES(ID_SETTLE_CYCLES)) u_id_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pullup_i(id_pullup_i),
    .valid_o (id_valid)
  );

  assign host_mode = dp_pulldown_i & dm_pulldown_i;

  always_comb begin
    src_eff                 = '0;
    src_eff[SRC_HOST_DISC]  = host_disc_i & host_mode & ~low_power_i;
    src_eff[SRC_VBUS]       = vbus_valid_i;
    src_eff[SRC_SESS_VALID] = sess_valid_i;
    src_eff[SRC_SESS_END]   = sess_end_i;
    src_eff[SRC_ID_GND]     = id_gnd_i & id_valid;
  end

  irq_edge_detect #(.N(NUM_SRC)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_eff),
    .rise_en_i(rise_en_i),
    .fall_en_i(fall_en_i),
    .event_o  (events)
  );

  assign rd_clr = reg_rd_i && (reg_addr_i == LATCH_ADDR);

  irq_latch_bank #(.N(NUM_SRC)) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .event_i    (events),
    .rd_clr_i   (rd_clr),
    .low_power_i(low_power_i),
    .serial_i   (serial_mode_i),
    .latch_o    (latch),
    .mode_clr_o (mode_clr),
    .irq_o      (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      STATUS_ADDR: reg_rdata_o = {{PAD_W{1'b0}}, src_eff};
      LATCH_ADDR:  reg_rdata_o = {{PAD_W{1'b0}}, latch};
      default:     reg_rdata_o = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R2: enabled rising edge is captured
    a_r2_rise_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && rise_en_i[i] && $rose(src_eff[i]) && !mode_clr) |=> latch[i]);
    // R3: enabled falling edge is captured
    a_r3_fall_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && fall_en_i[i] && $fell(src_eff[i]) && !mode_clr) |=> latch[i]);
    // R4: fully masked source never raises its bit
    a_r4_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rise_en_i[i] && !fall_en_i[i]) |=> !$rose(latch[i]));
  end
endmodule

// File: tb/usb_irq_latch_unit_tb_top.sv
module usb_irq_latch_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned SETTLE = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_disc = 0, vbus = 0, sess_valid = 0, sess_end = 0, id_gnd = 0;
  logic dp_pd = 0, dm_pd = 0, id_pu = 0, low_power = 0, serial = 0;
  logic [4:0] rise_en = '0, fall_en = '0;
  logic [7:0] addr = '0, rdata;
  logic rd = 1'b0, irq;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_latch_unit #(.ID_SETTLE_CYCLES(SETTLE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_disc_i(host_disc), .vbus_valid_i(vbus), .sess_valid_i(sess_valid),
    .sess_end_i(sess_end), .id_gnd_i(id_gnd),
    .dp_pulldown_i(dp_pd), .dm_pulldown_i(dm_pd), .id_pullup_i(id_pu),
    .rise_en_i(rise_en), .fall_en_i(fall_en),
    .low_power_i(low_power), .serial_mode_i(serial),
    .reg_addr_i(addr), .reg_rd_i(rd), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // driver: queue expectation, strobe for one cycle
  task automatic rd_reg(logic [7:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr = a; rd = 1'b1;
    step();
    rd = 1'b0; addr = '0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rd) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL scoreboard: unexpected read, actual %02h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R12 reset state
    @(negedge clk); check("R12 irq", {7'b0, irq}, 8'h00); step();
    rd_reg(8'h14, 8'h00, "R12 latch");
    rd_reg(8'h13, 8'h00, "R1 status idle");

    // R1 live status and bit order, unmapped address
    dp_pd = 1; dm_pd = 1;
    vbus = 1; sess_valid = 1;
    step();
    rd_reg(8'h13, 8'h06, "R1 status bits");
    rd_reg(8'h20, 8'h00, "R1 unmapped");
    rd_reg(8'h14, 8'h00, "R4 masked edges");

    // R4 disabled direction, R2 rising edge
    rise_en = 5'h1F; fall_en = 5'h00; step();
    vbus = 0; step();
    rd_reg(8'h14, 8'h00, "R4 fall not enabled");
    sess_end = 1; step();
    @(negedge clk); check("R11 irq set", {7'b0, irq}, 8'h01); step();
    rd_reg(8'h14, 8'h08, "R2 rise latched");
    rd_reg(8'h14, 8'h00, "R5 cleared by read");
    @(negedge clk); check("R11 irq clear", {7'b0, irq}, 8'h00); step();

    // R3 falling edge
    rise_en = 5'h00; fall_en = 5'h1F; step();
    sess_valid = 0; step();
    rd_reg(8'h14, 8'h04, "R3 fall latched");

    // R5 edge in same cycle as read
    rise_en = 5'h1F; step();
    vbus = 1;
    rd_reg(8'h14, 8'h00, "R5 read returns old");
    rd_reg(8'h14, 8'h02, "R5 new event kept");

    // R8 host mode gating
    dm_pd = 0; step();
    host_disc = 1; step();
    rd_reg(8'h13, 8'h0A, "R8 status not host");
    rd_reg(8'h14, 8'h00, "R8 no latch not host");
    dm_pd = 1; step();
    rd_reg(8'h13, 8'h0B, "R8 status host");
    rd_reg(8'h14, 8'h01, "R8 latch host");

    // R6 low-power entry clears, R9 host disconnect forced low
    sess_end = 0; step();
    @(negedge clk); check("R11 irq pending", {7'b0, irq}, 8'h01); step();
    low_power = 1; step();
    @(negedge clk); check("R6 irq after entry", {7'b0, irq}, 8'h00); step();
    rd_reg(8'h13, 8'h02, "R9 status in low power");
    rd_reg(8'h14, 8'h00, "R6 latch after entry");
    low_power = 0; step();
    rd_reg(8'h14, 8'h01, "R9 hd rise on exit");

    // R7 serial entry clears
    vbus = 0; step();
    @(negedge clk); check("R7 irq before entry", {7'b0, irq}, 8'h01); step();
    serial = 1; step();
    rd_reg(8'h14, 8'h00, "R7 latch after serial");
    serial = 0; step();

    // R10 ID settle window
    id_gnd = 1; step();
    rd_reg(8'h13, 8'h01, "R10 no pullup");
    id_pu = 1;
    repeat (8) step();
    rd_reg(8'h13, 8'h01, "R10 early");
    id_pu = 0; step();
    id_pu = 1;
    repeat (10) step();
    rd_reg(8'h13, 8'h01, "R10 restarted wait");
    rd_reg(8'h14, 8'h00, "R10 no early latch");
    repeat (10) step();
    rd_reg(8'h13, 8'h11, "R10 settled status");
    @(negedge clk); check("R11 irq id", {7'b0, irq}, 8'h01); step();
    rd_reg(8'h14, 8'h10, "R10 settled latch");
    @(negedge clk); check("R11 irq final", {7'b0, irq}, 8'h00); step();

    step();
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    report();
    $finish;
  end
endmodule